// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Unit

This block lets any of `NUM_CORES` processor cores ring a doorbell at any core, itself included. Each sender/target pair owns a trigger register, a 30-bit data register and an acknowledge register. A trigger write with the flag bit set latches a request. The target sees that request on its own level-sensitive interrupt line, if its busy mask admits that sender.

The target retires a request by writing one to the flag bit of the pair's acknowledge register. When the sender has enabled it in its done mask, that retirement latches a done flag that interrupts the sender in turn. The sender clears the flag by writing one to it. Software fills the data register first and writes the trigger register last, because only the trigger write raises the interrupt.

All registers sit on one memory-mapped bus. The address is made of three fields: `bus_addr[2:0]` selects the register, the next `IDX_W` bits hold the target index, and the top `IDX_W` bits hold the sender index. `IDX_W` is `$clog2(NUM_CORES)`, and `NUM_CORES` may be 2 to 8. Per-core registers use the sender field as the core index. Their target field must still be in range.

Top module: `core_doorbell_unit`

## Requirements
- R1: After a synchronous active-low reset, every latched request, stored message, data word, mask and done flag is zero, every `irq` bit is low and every register reads zero.
- R2: A write to the trigger register (code 0) with bit 31 set latches the pair's request and stores bits 30:0 as the message. Reading the trigger register returns {request, message}.
- R3: A trigger write with bit 31 clear replaces the message and leaves the pair's request bit unchanged.
- R4: The data register (code 1) keeps the low 30 bits of a write, reads with bits 31:30 zero, and writing it never changes any `irq` bit.
- R5: A write to the acknowledge register (code 2) with bit 31 set clears only that pair's request, which also shows as bit 31 of its trigger register. With bit 31 clear the write has no effect. The acknowledge register reads {request, 31 zeros}.
- R6: In the cycle after a register write, `irq[c]` is high exactly when some sender s, including s = c, has a latched request toward c with bit s of core c's busy mask (code 3) set, or core c has a done flag set.
- R7: A request whose sender is masked in the target's busy mask is still latched. It drives `irq` as soon as the mask bit is set.
- R8: An acknowledge that clears a latched request (s,t) sets bit t of sender s's done status (code 5) when bit t of s's done mask (code 4) is set. An acknowledge of a pair with no latched request sets nothing.
- R9: Writing ones to the done status register clears those bits. Done flags change only on a register write.
- R10: Register codes 6 and 7 read zero and ignore writes, and so does any access whose index fields are not below `NUM_CORES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3+2*IDX_W) | {sender index, target index, register code} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NUM_CORES | Level interrupt per core |

## Verification
On every cycle the assertions check four things. A flagged trigger write leaves its pair latched, and a flagged acknowledge leaves it clear. Requests and done flags hold still in cycles without a write. No `irq` bit is high while nothing is latched. The directed scenarios cover the rest: the exact read-back encodings, message-only trigger writes, masking and later unmasking, the self-addressed doorbell, and the done back-interrupt with its write-one-to-clear. They also show that reserved codes and data writes leave every other register and every interrupt as they were.

// File: rtl/cdb_pkg.sv
// Package cdb_pkg: register codes and field widths shared by the doorbell unit.
// Assumes a 32-bit data bus with the request flag in the top bit.
package cdb_pkg;
    localparam int DATA_W   = 32;
    localparam int FLAG_BIT = 31;
    localparam int MSG_W    = 31;
    localparam int XDATA_W  = 30;

    localparam logic [2:0] REG_TRIG  = 3'd0;
    localparam logic [2:0] REG_XDATA = 3'd1;
    localparam logic [2:0] REG_ACK   = 3'd2;
    localparam logic [2:0] REG_BMASK = 3'd3;
    localparam logic [2:0] REG_DMASK = 3'd4;
    localparam logic [2:0] REG_DSTAT = 3'd5;
endpackage

// File: rtl/cdb_decode.sv
// Module cdb_decode: splits the bus address into sender, target and register
// code, then turns a write into one-hot strobes per pair and per core.
// Assumes that an index at or above NUM_CORES makes the access void.
module cdb_decode
    import cdb_pkg::*;
#(
    parameter  int NUM_CORES = 4,
    localparam int IDX_W     = $clog2(NUM_CORES),
    localparam int ADDR_W    = 3 + 2 * IDX_W
) (
    input  logic                                  bus_we,
    input  logic [ADDR_W-1:0]                     bus_addr,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0]   trig_we,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0]   xdata_we,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0]   ack_we,
    output logic [NUM_CORES-1:0]                  bmask_we,
    output logic [NUM_CORES-1:0]                  dmask_we,
    output logic [NUM_CORES-1:0]                  dstat_we,
    output logic [IDX_W-1:0]                      src_idx,
    output logic [IDX_W-1:0]                      dst_idx,
    output logic [2:0]                            reg_sel,
    output logic                                  idx_ok
);
    // Address field extraction
    assign reg_sel = bus_addr[2:0];
    assign dst_idx = bus_addr[3 +: IDX_W];
    assign src_idx = bus_addr[3 + IDX_W +: IDX_W];

    // Both indices must name an existing core
    assign idx_ok = (int'(src_idx) < NUM_CORES) && (int'(dst_idx) < NUM_CORES);

    for (genvar s = 0; s < NUM_CORES; s++) begin : g_src
        // Per-core register strobes, core chosen by the sender field
        assign bmask_we[s] = bus_we && idx_ok && (reg_sel == REG_BMASK) && (src_idx == IDX_W'(s));
        assign dmask_we[s] = bus_we && idx_ok && (reg_sel == REG_DMASK) && (src_idx == IDX_W'(s));
        assign dstat_we[s] = bus_we && idx_ok && (reg_sel == REG_DSTAT) && (src_idx == IDX_W'(s));
        for (genvar t = 0; t < NUM_CORES; t++) begin : g_dst
            // Per-pair register strobes
            logic hit;
            assign hit = bus_we && idx_ok && (src_idx == IDX_W'(s)) && (dst_idx == IDX_W'(t));
            assign trig_we[s][t]  = hit && (reg_sel == REG_TRIG);
            assign xdata_we[s][t] = hit && (reg_sel == REG_XDATA);
            assign ack_we[s][t]   = hit && (reg_sel == REG_ACK);
        end
    end
endmodule

// File: rtl/cdb_pair.sv
// Module cdb_pair: storage of one sender/target pair, holding the latched
// request, the message and the data word. Reports an acknowledge event when a
// latched request is retired. Assumes a trigger strobe takes priority over an
// acknowledge in the same cycle.
module cdb_pair
    import cdb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_we,
    input  logic               xdata_we,
    input  logic               ack_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic               pend,
    output logic [MSG_W-1:0]   msg,
    output logic [XDATA_W-1:0] xdata,
    output logic               ack_evt
);
    // A flagged acknowledge of a latched request retires it
    assign ack_evt = ack_we && wdata[FLAG_BIT] && pend;

    // Request flag and message update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            msg  <= '0;
        end else if (trig_we) begin
            msg <= wdata[MSG_W-1:0];
            if (wdata[FLAG_BIT]) pend <= 1'b1;
        end else if (ack_evt) begin
            pend <= 1'b0;
        end
    end

    // Data word capture
    always_ff @(posedge clk) begin
        if (!rst_n)        xdata <= '0;
        else if (xdata_we) xdata <= wdata[XDATA_W-1:0];
    end
endmodule

// File: rtl/cdb_core.sv
// Module cdb_core: per-core control holding the busy mask, the done mask and
// the done flags, and forming the core's level interrupt. Assumes pend_in[s]
// is the request from sender s toward this core, and ack_evt[t] is the
// retirement of this core's request toward target t.
module cdb_core #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bmask_we,
    input  logic                 dmask_we,
    input  logic                 dstat_we,
    input  logic [NUM_CORES-1:0] wbits,
    input  logic [NUM_CORES-1:0] pend_in,
    input  logic [NUM_CORES-1:0] ack_evt,
    output logic [NUM_CORES-1:0] bmask,
    output logic [NUM_CORES-1:0] dmask,
    output logic [NUM_CORES-1:0] dstat,
    output logic                 irq
);
    logic [NUM_CORES-1:0] dstat_clr;

    // Mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bmask <= '0;
            dmask <= '0;
        end else begin
            if (bmask_we) bmask <= wbits;
            if (dmask_we) dmask <= wbits;
        end
    end

    // Write-one-to-clear selection for the done flags
    assign dstat_clr = dstat_we ? wbits : '0;

    // Done flags: set by an enabled retirement, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n) dstat <= '0;
        else        dstat <= (dstat & ~dstat_clr) | (ack_evt & dmask);
    end

    // Level interrupt from admitted requests and done flags
    assign irq = (|(pend_in & bmask)) | (|dstat);
endmodule

// File: rtl/core_doorbell_unit.sv
// Module core_doorbell_unit: top of the inter-core doorbell unit. Decodes the
// register bus, holds one cdb_pair per sender/target pair and one cdb_core
// per core, and multiplexes read data. Assumes a single bus master, with
// reads returned combinationally from the current address.
module core_doorbell_unit
    import cdb_pkg::*;
#(
    parameter  int NUM_CORES = 4,
    localparam int IDX_W     = $clog2(NUM_CORES),
    localparam int ADDR_W    = 3 + 2 * IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] irq
);
    logic [NUM_CORES-1:0][NUM_CORES-1:0]              trig_we, xdata_we, ack_we;
    logic [NUM_CORES-1:0]                             bmask_we, dmask_we, dstat_we;
    logic [IDX_W-1:0]                                 src_idx, dst_idx;
    logic [2:0]                                       reg_sel;
    logic                                             idx_ok;
    logic [NUM_CORES-1:0][NUM_CORES-1:0]              pend_st;
    logic [NUM_CORES-1:0][NUM_CORES-1:0]              pend_ts;
    logic [NUM_CORES-1:0][NUM_CORES-1:0]              ack_evt_st;
    logic [NUM_CORES-1:0][NUM_CORES-1:0][MSG_W-1:0]   msg_st;
    logic [NUM_CORES-1:0][NUM_CORES-1:0][XDATA_W-1:0] xdata_st;
    logic [NUM_CORES-1:0][NUM_CORES-1:0]              bmask_q, dmask_q, dstat_q;

    cdb_decode #(.NUM_CORES(NUM_CORES)) u_decode (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .trig_we  (trig_we),
        .xdata_we (xdata_we),
        .ack_we   (ack_we),
        .bmask_we (bmask_we),
        .dmask_we (dmask_we),
        .dstat_we (dstat_we),
        .src_idx  (src_idx),
        .dst_idx  (dst_idx),
        .reg_sel  (reg_sel),
        .idx_ok   (idx_ok)
    );

    for (genvar s = 0; s < NUM_CORES; s++) begin : g_s
        for (genvar t = 0; t < NUM_CORES; t++) begin : g_t
            cdb_pair u_pair (
                .clk      (clk),
                .rst_n    (rst_n),
                .trig_we  (trig_we[s][t]),
                .xdata_we (xdata_we[s][t]),
                .ack_we   (ack_we[s][t]),
                .wdata    (bus_wdata),
                .pend     (pend_st[s][t]),
                .msg      (msg_st[s][t]),
                .xdata    (xdata_st[s][t]),
                .ack_evt  (ack_evt_st[s][t])
            );
            // Target-major view of the request flags
            assign pend_ts[t][s] = pend_st[s][t];
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        cdb_core #(.NUM_CORES(NUM_CORES)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .bmask_we (bmask_we[c]),
            .dmask_we (dmask_we[c]),
            .dstat_we (dstat_we[c]),
            .wbits    (bus_wdata[NUM_CORES-1:0]),
            .pend_in  (pend_ts[c]),
            .ack_evt  (ack_evt_st[c]),
            .bmask    (bmask_q[c]),
            .dmask    (dmask_q[c]),
            .dstat    (dstat_q[c]),
            .irq      (irq[c])
        );
    end

    // Read data selection
    always_comb begin
        bus_rdata = '0;
        if (idx_ok) begin
            case (reg_sel)
                REG_TRIG:  bus_rdata = {pend_st[src_idx][dst_idx], msg_st[src_idx][dst_idx]};
                REG_XDATA: bus_rdata = {{(DATA_W-XDATA_W){1'b0}}, xdata_st[src_idx][dst_idx]};
                REG_ACK:   bus_rdata = {pend_st[src_idx][dst_idx], {MSG_W{1'b0}}};
                REG_BMASK: bus_rdata[NUM_CORES-1:0] = bmask_q[src_idx];
                REG_DMASK: bus_rdata[NUM_CORES-1:0] = dmask_q[src_idx];
                REG_DSTAT: bus_rdata[NUM_CORES-1:0] = dstat_q[src_idx];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cdb_checker.sv
// Module cdb_checker: temporal properties of the doorbell unit, attached to
// the top module through bind. Assumes the sender-major request matrix and
// the done flags are visible as ports.
module cdb_checker
    import cdb_pkg::*;
#(
    parameter  int NUM_CORES = 4,
    localparam int IDX_W     = $clog2(NUM_CORES),
    localparam int ADDR_W    = 3 + 2 * IDX_W
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                bus_we,
    input logic [ADDR_W-1:0]                   bus_addr,
    input logic [DATA_W-1:0]                   bus_wdata,
    input logic [NUM_CORES-1:0]                irq,
    input logic [NUM_CORES-1:0][NUM_CORES-1:0] pend_st,
    input logic [NUM_CORES-1:0][NUM_CORES-1:0] dstat_q
);
    logic [IDX_W-1:0] w_src, w_dst;
    logic [2:0]       w_reg;
    logic             w_ok;

    // Independent view of the addressed pair
    assign w_reg = bus_addr[2:0];
    assign w_dst = bus_addr[3 +: IDX_W];
    assign w_src = bus_addr[3 + IDX_W +: IDX_W];
    assign w_ok  = (int'(w_src) < NUM_CORES) && (int'(w_dst) < NUM_CORES);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pend_st == '0 && dstat_q == '0 && irq == '0)); // R1

    AST_TRIG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && w_ok && w_reg == REG_TRIG && bus_wdata[FLAG_BIT])
        |=> pend_st[$past(w_src)][$past(w_dst)]); // R2

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && w_ok && w_reg == REG_ACK && bus_wdata[FLAG_BIT])
        |=> !pend_st[$past(w_src)][$past(w_dst)]); // R5

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_st == '0 && dstat_q == '0) |-> (irq == '0)); // R6

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pend_st)); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(dstat_q)); // R9
endmodule

bind core_doorbell_unit cdb_checker #(.NUM_CORES(NUM_CORES)) u_cdb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .pend_st   (pend_st),
    .dstat_q   (dstat_q)
);

// File: tb/core_doorbell_unit_bench.sv
`timescale 1ns/1ps
// Bench core_doorbell_unit_bench: directed scenarios, one task each, for the
// doorbell unit with four cores. Inputs change and outputs are sampled on the
// falling clock edge.
module core_doorbell_unit_bench;
    localparam int N      = 4;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = 3 + 2 * IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N-1:0]      irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    core_doorbell_unit #(.NUM_CORES(N)) u_core_doorbell_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [ADDR_W-1:0] ad(input int s, input int t, input logic [2:0] r);
        return {IDX_W'(s), IDX_W'(t), r};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int s, input int t, input logic [2:0] r, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = ad(s, t, r);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int s, input int t, input logic [2:0] r, output logic [31:0] d);
        bus_addr = ad(s, t, r);
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(1, 3, 3'd0, d); check("R1 trigger after reset", d, 32'h0);
        rd(2, 0, 3'd3, d); check("R1 busy mask after reset", d, 32'h0);
        check("R1 irq after reset", {28'h0, irq}, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        do_reset();
        wr(2, 0, 3'd3, 32'hF);
        wr(0, 2, 3'd0, 32'h8100_0002);
        rd(0, 2, 3'd0, d); check("R2 trigger readback", d, 32'h8100_0002);
        rd(0, 2, 3'd2, d); check("R5 ack readback", d, 32'h8000_0000);
        check("R6 irq to core 2", {28'h0, irq}, 32'h4);
    endtask

    task automatic t_msg_only();
        logic [31:0] d;
        do_reset();
        wr(1, 3, 3'd0, 32'h8000_0011);
        wr(1, 3, 3'd0, 32'h0000_0055);
        rd(1, 3, 3'd0, d); check("R3 message update keeps request", d, 32'h8000_0055);
        do_reset();
        wr(1, 3, 3'd0, 32'h0000_0012);
        rd(1, 3, 3'd0, d); check("R3 message without request", d, 32'h0000_0012);
    endtask

    task automatic t_xdata();
        logic [31:0] d;
        do_reset();
        for (int c = 0; c < N; c++) wr(c, 0, 3'd3, 32'hF);
        wr(2, 1, 3'd1, 32'hFFFF_FFFF);
        rd(2, 1, 3'd1, d); check("R4 data width", d, 32'h3FFF_FFFF);
        check("R4 data write raises nothing", {28'h0, irq}, 32'h0);
        wr(2, 1, 3'd0, 32'h8000_0000);
        check("R6 trigger after data", {28'h0, irq}, 32'h2);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        do_reset();
        wr(1, 0, 3'd3, 32'hF);
        wr(3, 0, 3'd3, 32'hF);
        wr(0, 1, 3'd0, 32'h8000_0000);
        wr(2, 3, 3'd0, 32'h8000_0000);
        check("R6 two targets", {28'h0, irq}, 32'hA);
        wr(0, 1, 3'd2, 32'h7FFF_FFFF);
        check("R5 ack without flag ignored", {28'h0, irq}, 32'hA);
        wr(0, 1, 3'd2, 32'h8000_0000);
        check("R5 ack clears one pair", {28'h0, irq}, 32'h8);
        rd(0, 1, 3'd0, d); check("R5 trigger flag cleared", d, 32'h0);
        rd(2, 3, 3'd0, d); check("R5 other pair untouched", d, 32'h8000_0000);
    endtask

    task automatic t_self_mask();
        do_reset();
        wr(3, 0, 3'd3, 32'h8);
        wr(3, 3, 3'd0, 32'h8000_0000);
        check("R6 self doorbell", {28'h0, irq}, 32'h8);
        wr(0, 3, 3'd0, 32'h8000_0000);
        wr(3, 3, 3'd2, 32'h8000_0000);
        check("R7 masked sender silent", {28'h0, irq}, 32'h0);
        wr(3, 0, 3'd3, 32'h1);
        check("R7 unmask raises latched request", {28'h0, irq}, 32'h8);
    endtask

    task automatic t_done();
        logic [31:0] d;
        do_reset();
        wr(2, 0, 3'd3, 32'hF);
        wr(0, 0, 3'd4, 32'h4);
        wr(0, 2, 3'd0, 32'h8000_0000);
        check("R6 request to core 2", {28'h0, irq}, 32'h4);
        wr(0, 2, 3'd2, 32'h8000_0000);
        check("R8 done interrupts sender", {28'h0, irq}, 32'h1);
        rd(0, 0, 3'd5, d); check("R8 done status bit", d, 32'h4);
        wr(0, 0, 3'd5, 32'h4);
        rd(0, 0, 3'd5, d); check("R9 done status cleared", d, 32'h0);
        check("R9 irq after clear", {28'h0, irq}, 32'h0);
        wr(0, 2, 3'd2, 32'h8000_0000);
        rd(0, 0, 3'd5, d); check("R8 ack of idle pair sets nothing", d, 32'h0);
        wr(1, 2, 3'd0, 32'h8000_0000);
        wr(1, 2, 3'd2, 32'h8000_0000);
        rd(1, 0, 3'd5, d); check("R8 done masked off", d, 32'h0);
        check("R8 irq with done masked off", {28'h0, irq}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        do_reset();
        wr(0, 0, 3'd6, 32'hFFFF_FFFF);
        wr(0, 0, 3'd7, 32'hFFFF_FFFF);
        rd(0, 0, 3'd6, d); check("R10 code 6 reads zero", d, 32'h0);
        rd(0, 0, 3'd7, d); check("R10 code 7 reads zero", d, 32'h0);
        rd(0, 0, 3'd0, d); check("R10 trigger untouched", d, 32'h0);
        rd(0, 0, 3'd3, d); check("R10 busy mask untouched", d, 32'h0);
        check("R10 irq untouched", {28'h0, irq}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_trigger();
        t_msg_only();
        t_xdata();
        t_ack();
        t_self_mask();
        t_done();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule